// File: doc/BRIEF.md
# Seventeen-Level PWM Gate Pattern Generator

This block is the digital modulator for a single-source switched-capacitor inverter with seventeen output steps. A phase accumulator advances by a programmable frequency word each enabled cycle. A quarter-wave sine table is addressed from that phase, and its output is scaled by a modulation index to give the magnitude of the reference. The sign of the reference comes from the top phase bit. The magnitude is compared against eight stacked triangular carriers. All eight carriers are derived from one shared up/down counter, and each sits one band above the one below it. The number of carriers the magnitude exceeds gives the output step, from -8 to +8.

The step and the polarity together select a pattern for the thirteen power switches. Polarity is steered by two dedicated switch pairs, and the pattern also turns on the switches that recharge the capacitors. A dead-time stage holds back every switch that is about to turn on for a programmable number of cycles, while switches that turn off drop at once. With the enable low, or with reset asserted, all gates are held off.

Top module: `p17_gate_gen`

## Requirements
- R1: `level_o` is a two's-complement 5-bit value that always lies between -8 and +8.
- R2: The level magnitude equals the number of carriers k (k = 0..7) for which the reference magnitude is greater than k*256 plus the shared carrier count. The carrier count sweeps 0..255 and back. The reference peak scales with `mod_idx_i`, so an index of 255 reaches magnitude 8, an index of 128 never exceeds magnitude 4, and an index of 0 keeps the level at 0.
- R3: The phase starts at 0 and grows by `freq_word_i` on every enabled clock. A positive level appears only when bit 31 of the phase used for that level is 0, and a negative level only when that bit is 1.
- R4: Gate bit k-1 drives switch Sk. Every positive level turns on S2 and S3. The additional switches per level are: +1 {S7,S8,S11}; +2 {S7,S11,S12,S13}; +3 {S7,S8,S9}; +4 {S7,S9,S10,S12}; +5 {S5,S6,S8,S11}; +6 {S5,S6,S11,S12,S13}; +7 {S5,S6,S8,S9}; +8 {S5,S6,S9,S12}.
- R5: Every negative level turns on S1 and S4 in place of S2 and S3. S6..S13 are the same as for the matching positive magnitude. S5 is on for magnitudes 1 to 4 and off for magnitudes 5 to 8.
- R6: Level 0 selects {S1,S3,S5} when the most recent nonzero level was positive, or when there has been no nonzero level since the block was enabled. It selects {S2,S4} when the most recent nonzero level was negative.
- R7: The charging switches follow the magnitude: S8 is on for every odd magnitude, S13 only for magnitudes 2 and 6, and S10 only for magnitude 4.
- R8: After `level_o` changes, a switch that the new pattern turns on stays off for the next DEAD_CYC+1 cycles. It appears DEAD_CYC+2 cycles after the change, at which point `gate_o` equals the new pattern.
- R9: One cycle after `level_o` changes, `gate_o` equals its previous value ANDed with the new pattern, so switches that turn off drop at once.
- R10: While reset is asserted, and one cycle after `en_i` is sampled low, `gate_o` is all zeros and `level_o` is 0.
- R11: S1 and S2 are never on together, and S3 and S4 are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; low clears phase, carrier and gates |
| freq_word_i | input | 32 | Phase increment per clock |
| mod_idx_i | input | 8 | Modulation index, 255 approximately full scale |
| gate_o | output | 13 | Switch gates, bit k-1 drives Sk |
| level_o | output | 5 | Selected signed output step |

## Verification
The assertions check the following on every cycle: the level stays in range, the carrier count stays within its band, the two polarity leg pairs are never both on, a disable clears the outputs one cycle later, no gate survives once it has left the target pattern, and a gate rises only after the target has been steady. Some behaviours can only be shown by the bench scenarios. These are the exact switch sets per level and polarity, the choice of zero state by the last polarity, the charging-switch mapping, and the exact cycle on which delayed switches appear. The same holds for the sign of each level against an independent phase model, and for how the peak level depends on the modulation index, which needs whole fundamental periods at full, half and zero index.

// File: rtl/p17_pkg.sv
package p17_pkg;
    localparam int NUM_SW = 13;
    localparam int LVL_W  = 5;
    // gate bit index for switch Sk is k-1
    localparam int S1  = 0;
    localparam int S2  = 1;
    localparam int S3  = 2;
    localparam int S4  = 3;
    localparam int S5  = 4;
    localparam int S6  = 5;
    localparam int S7  = 6;
    localparam int S8  = 7;
    localparam int S9  = 8;
    localparam int S10 = 9;
    localparam int S11 = 10;
    localparam int S12 = 11;
    localparam int S13 = 12;
endpackage

// File: rtl/p17_ref_gen.sv
module p17_ref_gen #(
    parameter int PHASE_W = 32,
    parameter int LUT_AW  = 6,
    parameter int SIN_W   = 12,
    parameter int MI_W    = 8,
    parameter int REF_W   = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [PHASE_W-1:0] freq,
    input  logic [MI_W-1:0]    mi,
    output logic [REF_W-1:0]   ref_abs,
    output logic               ref_neg
);
    localparam int LUT_N  = 1 << LUT_AW;
    localparam int PROD_W = SIN_W + MI_W;
    localparam int SHIFT  = PROD_W - REF_W;
    localparam int LOW_W  = PHASE_W - 2 - LUT_AW;

    // integer rational sine approximation over one quarter wave
    function automatic logic [SIN_W-1:0] sine_pt(input int idx);
        longint x;
        longint h;
        longint num;
        longint den;
        x   = longint'(idx);
        h   = 2 * longint'(LUT_N);
        num = 4 * x * (h - x);
        den = (5 * h * h) / 4 - x * (h - x);
        return SIN_W'((((longint'(1) << SIN_W) - 1) * num) / den);
    endfunction

    logic [SIN_W-1:0] lut [LUT_N];
    for (genvar g = 0; g < LUT_N; g++) begin : g_lut
        assign lut[g] = sine_pt(g);
    end

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
    } ref_st_t;

    ref_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) st_d.phase = st_q.phase + freq;
        else    st_d.phase = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    logic [LUT_AW-1:0] addr_raw, addr;
    logic [SIN_W-1:0]  sine;
    logic [PROD_W-1:0] prod;

    assign addr_raw = st_q.phase[PHASE_W-3 -: LUT_AW];
    assign addr     = st_q.phase[PHASE_W-2] ? ~addr_raw : addr_raw;
    assign sine     = lut[addr];
    assign prod     = {{MI_W{1'b0}}, sine} * {{SIN_W{1'b0}}, mi};
    assign ref_abs  = prod[PROD_W-1 -: REF_W];
    assign ref_neg  = st_q.phase[PHASE_W-1];

    logic unused_low_bits;
    assign unused_low_bits = ^{st_q.phase[LOW_W-1:0], prod[SHIFT-1:0]};
endmodule

// File: rtl/p17_level_sel.sv
module p17_level_sel
    import p17_pkg::*;
#(
    parameter int NLEV    = 8,
    parameter int BAND_W  = 8,
    parameter int CAR_DIV = 20,
    parameter int REF_W   = 11
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic [REF_W-1:0]        ref_abs,
    input  logic                    ref_neg,
    output logic signed [LVL_W-1:0] level,
    output logic                    pol_neg
);
    localparam int BAND  = 1 << BAND_W;
    localparam int DIV_W = (CAR_DIV > 1) ? $clog2(CAR_DIV) : 1;
    localparam int MAG_W = $clog2(NLEV + 1);
    localparam int CMP_W = REF_W + 1;

    typedef struct packed {
        logic [BAND_W-1:0]        cnt;
        logic                     down;
        logic [DIV_W-1:0]         div;
        logic signed [LVL_W-1:0]  level;
        logic                     pol_neg;
    } lvl_st_t;

    lvl_st_t st_d, st_q;

    // one comparator per stacked carrier
    logic [NLEV-1:0] exceed;
    for (genvar g = 0; g < NLEV; g++) begin : g_cmp
        assign exceed[g] = {1'b0, ref_abs} > (CMP_W'(g * BAND) + CMP_W'(st_q.cnt));
    end

    logic [MAG_W-1:0] mag;
    logic [LVL_W-1:0] mag_ext;

    always_comb begin
        mag = '0;
        for (int k = 0; k < NLEV; k++) mag = mag + MAG_W'(exceed[k]);
        mag_ext = LVL_W'(mag);
        st_d = st_q;
        if (!en) begin
            st_d = '0;
        end else begin
            if (st_q.div == DIV_W'(CAR_DIV - 1)) begin
                st_d.div = '0;
                if (!st_q.down) begin
                    if (st_q.cnt == BAND_W'(BAND - 1)) begin
                        st_d.down = 1'b1;
                        st_d.cnt  = st_q.cnt - 1'b1;
                    end else begin
                        st_d.cnt  = st_q.cnt + 1'b1;
                    end
                end else begin
                    if (st_q.cnt == '0) begin
                        st_d.down = 1'b0;
                        st_d.cnt  = st_q.cnt + 1'b1;
                    end else begin
                        st_d.cnt  = st_q.cnt - 1'b1;
                    end
                end
            end else begin
                st_d.div = st_q.div + 1'b1;
            end
            st_d.level = ref_neg ? -$signed(mag_ext) : $signed(mag_ext);
            if (mag != '0) st_d.pol_neg = ref_neg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign level   = st_q.level;
    assign pol_neg = st_q.pol_neg;

    a_r1_level_in_range: assert property (@(posedge clk) disable iff (rst)
        (st_q.level >= -LVL_W'(NLEV)) && (st_q.level <= LVL_W'(NLEV)));

    a_r2_carrier_bounded: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt == BAND_W'(BAND - 1)) |=> !$rose(st_q.cnt == '0));
endmodule

// File: rtl/p17_gate_map.sv
module p17_gate_map
    import p17_pkg::*;
(
    input  logic signed [LVL_W-1:0] level,
    input  logic                    pol_neg,
    output logic [NUM_SW-1:0]       tgt
);
    logic       neg;
    logic [3:0] mag;
    logic [3:0] idx;

    always_comb begin
        neg = level < 0;
        mag = neg ? 4'(-level) : 4'(level);
        idx = mag - 4'd1;
        tgt = '0;
        if (mag == 4'd0) begin
            if (pol_neg) begin
                tgt[S2] = 1'b1;
                tgt[S4] = 1'b1;
            end else begin
                tgt[S1] = 1'b1;
                tgt[S3] = 1'b1;
                tgt[S5] = 1'b1;
            end
        end else begin
            if (neg) begin
                tgt[S1] = 1'b1;
                tgt[S4] = 1'b1;
            end else begin
                tgt[S2] = 1'b1;
                tgt[S3] = 1'b1;
            end
            // capacitor charge switches
            tgt[S8]  = mag[0];
            tgt[S13] = (mag == 4'd2) || (mag == 4'd6);
            tgt[S10] = (mag == 4'd4);
            // series path selection
            tgt[S9]  = idx[1];
            tgt[S11] = !idx[1];
            tgt[S12] = !mag[0];
            tgt[S7]  = (mag <= 4'd4);
            tgt[S6]  = (mag >= 4'd5);
            tgt[S5]  = neg ? (mag <= 4'd4) : (mag >= 4'd5);
        end
    end
endmodule

// File: rtl/p17_dead_time.sv
module p17_dead_time
    import p17_pkg::*;
#(
    parameter int DEAD_CYC = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [NUM_SW-1:0] tgt_i,
    output logic [NUM_SW-1:0] gate
);
    localparam int CNT_W = $clog2(DEAD_CYC + 1);

    typedef struct packed {
        logic [NUM_SW-1:0] tgt;
        logic [NUM_SW-1:0] gate;
        logic [CNT_W-1:0]  cnt;
    } dt_st_t;

    dt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = '0;
        end else if (tgt_i != st_q.tgt) begin
            st_d.tgt  = tgt_i;
            st_d.gate = tgt_i & st_q.gate;
            st_d.cnt  = CNT_W'(DEAD_CYC);
        end else if (st_q.cnt != '0) begin
            st_d.gate = tgt_i & st_q.gate;
            st_d.cnt  = st_q.cnt - 1'b1;
        end else begin
            st_d.gate = tgt_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign gate = st_q.gate;

    a_r8_rise_after_steady: assert property (@(posedge clk) disable iff (rst)
        ((st_q.gate & ~$past(st_q.gate)) != '0) |-> ($past(tgt_i) == $past(tgt_i, 2)));

    a_r9_off_follows_target: assert property (@(posedge clk) disable iff (rst)
        (st_q.gate & ~$past(tgt_i)) == '0);
endmodule

// File: rtl/p17_gate_gen.sv
module p17_gate_gen
    import p17_pkg::*;
#(
    parameter int PHASE_W  = 32,
    parameter int LUT_AW   = 6,
    parameter int SIN_W    = 12,
    parameter int MI_W     = 8,
    parameter int NLEV     = 8,
    parameter int BAND_W   = 8,
    parameter int CAR_DIV  = 20,
    parameter int DEAD_CYC = 100
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    en_i,
    input  logic [PHASE_W-1:0]      freq_word_i,
    input  logic [MI_W-1:0]         mod_idx_i,
    output logic [NUM_SW-1:0]       gate_o,
    output logic signed [LVL_W-1:0] level_o
);
    localparam int REF_W = BAND_W + $clog2(NLEV);

    logic [REF_W-1:0]        ref_abs;
    logic                    ref_neg;
    logic signed [LVL_W-1:0] level;
    logic                    pol_neg;
    logic [NUM_SW-1:0]       tgt;

    p17_ref_gen #(
        .PHASE_W(PHASE_W), .LUT_AW(LUT_AW), .SIN_W(SIN_W), .MI_W(MI_W), .REF_W(REF_W)
    ) u_ref (
        .clk(clk_i), .rst(rst_i), .en(en_i), .freq(freq_word_i), .mi(mod_idx_i),
        .ref_abs(ref_abs), .ref_neg(ref_neg)
    );

    p17_level_sel #(
        .NLEV(NLEV), .BAND_W(BAND_W), .CAR_DIV(CAR_DIV), .REF_W(REF_W)
    ) u_lvl (
        .clk(clk_i), .rst(rst_i), .en(en_i), .ref_abs(ref_abs), .ref_neg(ref_neg),
        .level(level), .pol_neg(pol_neg)
    );

    p17_gate_map u_map (
        .level(level), .pol_neg(pol_neg), .tgt(tgt)
    );

    p17_dead_time #(
        .DEAD_CYC(DEAD_CYC)
    ) u_dt (
        .clk(clk_i), .rst(rst_i), .en(en_i), .tgt_i(tgt), .gate(gate_o)
    );

    assign level_o = level;

    a_r10_disable_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (gate_o == '0 && level_o == '0));

    a_r11_legs_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
        !(gate_o[S1] && gate_o[S2]) && !(gate_o[S3] && gate_o[S4]));
endmodule

// File: tb/p17_gate_gen_tb.sv
module p17_gate_gen_tb;
    localparam int TB_DEAD = 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               en  = 1'b0;
    logic [31:0]        fw  = '0;
    logic [7:0]         mi  = '0;
    logic [12:0]        gate_o;
    logic signed [4:0]  level_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    p17_gate_gen #(.CAR_DIV(1), .DEAD_CYC(TB_DEAD)) u_dut (
        .clk_i(clk), .rst_i(rst), .en_i(en), .freq_word_i(fw), .mod_idx_i(mi),
        .gate_o(gate_o), .level_o(level_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [12:0] sw(input int k);
        return 13'(1) << (k - 1);
    endfunction

    function automatic logic [12:0] pat(input int lvl, input bit lastneg);
        case (lvl)
             0: return lastneg ? (sw(2) | sw(4)) : (sw(1) | sw(3) | sw(5));
             1: return sw(2) | sw(3) | sw(7) | sw(8) | sw(11);
             2: return sw(2) | sw(3) | sw(7) | sw(11) | sw(12) | sw(13);
             3: return sw(2) | sw(3) | sw(7) | sw(8) | sw(9);
             4: return sw(2) | sw(3) | sw(7) | sw(9) | sw(10) | sw(12);
             5: return sw(2) | sw(3) | sw(5) | sw(6) | sw(8) | sw(11);
             6: return sw(2) | sw(3) | sw(5) | sw(6) | sw(11) | sw(12) | sw(13);
             7: return sw(2) | sw(3) | sw(5) | sw(6) | sw(8) | sw(9);
             8: return sw(2) | sw(3) | sw(5) | sw(6) | sw(9) | sw(12);
            -1: return sw(1) | sw(4) | sw(5) | sw(7) | sw(8) | sw(11);
            -2: return sw(1) | sw(4) | sw(5) | sw(7) | sw(11) | sw(12) | sw(13);
            -3: return sw(1) | sw(4) | sw(5) | sw(7) | sw(8) | sw(9);
            -4: return sw(1) | sw(4) | sw(5) | sw(7) | sw(9) | sw(10) | sw(12);
            -5: return sw(1) | sw(4) | sw(6) | sw(8) | sw(11);
            -6: return sw(1) | sw(4) | sw(6) | sw(11) | sw(12) | sw(13);
            -7: return sw(1) | sw(4) | sw(6) | sw(8) | sw(9);
            -8: return sw(1) | sw(4) | sw(6) | sw(9) | sw(12);
            default: return '1;
        endcase
    endfunction

    // independent phase model for the sign requirement
    logic [31:0] ph_m = '0;
    logic        sign_m = 1'b0;
    always @(posedge clk) begin
        sign_m <= ph_m[31];
        ph_m   <= (rst || !en) ? 32'd0 : ph_m + fw;
    end

    int          prev_level = 0;
    int          stable_n   = 0;
    logic [12:0] gate_at0   = '0;
    logic [12:0] newpat     = '0;
    bit          lastneg    = 0;
    int          maxmag     = 0;
    bit          pos_seen   = 0;
    bit          neg_seen   = 0;

    always @(negedge clk) begin
        int lv;
        int mg;
        string req;
        lv = int'(level_o);
        if (rst || !en) begin
            check(gate_o == '0, "R10 gates off", int'(gate_o), 0);
            check(lv == 0, "R10 level zero", lv, 0);
            stable_n   = 0;
            gate_at0   = '0;
            newpat     = pat(0, 1'b0);
            prev_level = 0;
            lastneg    = 0;
        end else begin
            if (lv != prev_level) begin
                stable_n = 0;
                gate_at0 = gate_o;
                newpat   = pat(lv, lastneg);
            end else begin
                stable_n++;
            end
            check(lv >= -8 && lv <= 8, "R1 range", lv, 0);
            check(!(gate_o[0] && gate_o[1]) && !(gate_o[2] && gate_o[3]),
                  "R11 legs", int'(gate_o), 0);
            if (lv > 0) check(sign_m == 1'b0, "R3 positive sign", int'(sign_m), 0);
            if (lv < 0) check(sign_m == 1'b1, "R3 negative sign", int'(sign_m), 1);
            if (stable_n == 1)
                check(gate_o == (gate_at0 & newpat), "R9 immediate off",
                      int'(gate_o), int'(gate_at0 & newpat));
            if (stable_n == TB_DEAD + 1)
                check(gate_o == (gate_at0 & newpat), "R8 turn-on held",
                      int'(gate_o), int'(gate_at0 & newpat));
            if (stable_n == TB_DEAD + 2) begin
                req = (lv > 0) ? "R4 positive pattern" : ((lv < 0) ? "R5 negative pattern" : "R6 zero pattern");
                check(gate_o == newpat, req, int'(gate_o), int'(newpat));
                mg = (lv < 0) ? -lv : lv;
                check(gate_o[7] == ((mg % 2) == 1), "R7 S8 charge", int'(gate_o[7]), int'((mg % 2) == 1));
                check(gate_o[12] == (mg == 2 || mg == 6), "R7 S13 charge", int'(gate_o[12]), int'(mg == 2 || mg == 6));
                check(gate_o[9] == (mg == 4), "R7 S10 charge", int'(gate_o[9]), int'(mg == 4));
            end
            if (lv != 0) lastneg = (lv < 0);
            prev_level = lv;
            mg = (lv < 0) ? -lv : lv;
            if (mg > maxmag) maxmag = mg;
            if (lv > 0) pos_seen = 1;
            if (lv < 0) neg_seen = 1;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        step(5);
        check(gate_o == '0 && level_o == 0, "R10 reset state", int'(gate_o), 0);
        rst = 1'b0;
        step(2);

        // full index, one fundamental of 25600 cycles
        fw = 32'd167772; mi = 8'd255; maxmag = 0; pos_seen = 0; neg_seen = 0;
        en = 1'b1;
        step(25700);
        check(maxmag == 8, "R2 full index peak", maxmag, 8);
        check(pos_seen && neg_seen, "R3 both polarities", int'(pos_seen) + int'(neg_seen), 2);

        // disable clears outputs
        en = 1'b0;
        step(1);
        check(gate_o == '0 && level_o == 0, "R10 disable", int'(gate_o), 0);
        step(3);

        // half index
        mi = 8'd128; maxmag = 0;
        en = 1'b1;
        step(25700);
        check(maxmag == 4, "R2 half index peak", maxmag, 4);

        // zero index
        en = 1'b0; step(2);
        mi = 8'd0; maxmag = 0; en = 1'b1;
        step(4000);
        check(maxmag == 0, "R2 zero index", maxmag, 0);
        check(gate_o == pat(0, 1'b0), "R6 zero state after enable", int'(gate_o), int'(pat(0, 1'b0)));

        // random segments
        for (int s = 0; s < 6; s++) begin
            mi = 8'(140 + ($urandom % 116));
            fw = 32'(100000 + ($urandom % 300000));
            step(6000);
            if (($urandom % 2) == 1) begin
                en = 1'b0;
                step(1 + ($urandom % 3));
                en = 1'b1;
            end
        end
        step(20);
        finish_run();
    end
endmodule